// File: doc/BRIEF.md
# Host Port Outbound DMA Read Handshake

This block is the slave end of a processor host port that streams 32-bit words out to an external DMA controller. It has two stages. A holding register is filled by the processor's own DMA engine. An output register is the one the external master reads. When the holding register is empty, the block asks the internal engine for a new word. When the output register holds a word and the receive-request mode bit is set, the block asks the external controller to collect it.

The external controller reads by strobing an acknowledge input. No address is involved. The word appears on the data bus in the same cycle as the acknowledge, with no wait states. On the next edge the output register is marked empty, and on the edge after that the word waiting in the holding register moves across. This refills the output stage and asks the internal engine for the next word. The two handshakes keep running like this without any software involvement.

Top module: `hostport_dma_rd`

## Requirements
- R1: After a synchronous active-low reset, `hold_empty` is 1, `out_full` is 0 and `ext_req` is 0.
- R2: `ext_req` is 1 exactly when the output register is full and `rx_req_en` is 1. Clearing `rx_req_en` masks the request without disturbing the data or the flags.
- R3: An `ext_ack` sampled at a clock edge while the output register is full empties it at that edge, so `ext_req` falls on the following cycle.
- R4: When the holding register is full and the output register is empty at a clock edge, the held word moves into the output register at that edge. As a result `out_full` becomes 1 and `hold_empty` becomes 1.
- R5: A `hold_wr` pulse at a clock edge stores `hold_wdata` and makes `hold_empty` 0 after that edge. If the output register was empty, the word moves across on the next edge.
- R6: `dout_oe` equals `ext_ack`. While `ext_ack` is 1, `dout` carries the output register contents in the same cycle, with no wait state.
- R7: An `ext_ack` while the output register is empty is ignored. Both flags and both registers keep their values.
- R8: A stream of words written to the holding register reaches the external reader in the order written, with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_req_en | input | 1 | Receive-request mode enable; gates `ext_req` |
| ext_req | output | 1 | Service request to the external DMA controller |
| ext_ack | input | 1 | Read strobe from the external DMA controller |
| dout | output | DATA_W | Output register contents on the shared bus |
| dout_oe | output | 1 | Bus drive enable (the bus is tri-state when 0) |
| hold_wr | input | 1 | Write strobe from the internal DMA engine |
| hold_wdata | input | DATA_W | Word written to the holding register |
| hold_empty | output | 1 | Holding register empty; request to the internal DMA engine |
| out_full | output | 1 | Output register holds an unread word |

## Verification
The bench builds the block with the default DATA_W of 32. At that width, distinct word values make any loss, duplication or reordering visible across the whole stream. The bench drives several acknowledge rhythms against it: back-to-back, sparse, and strobes while the output register is empty. It also varies how slowly the internal engine refills the holding register, so that both the refill-on-empty path and the move-after-read path occur. In one phase the bench clears the mode enable while data is pending, to show that the request is masked while the data is kept.

// File: rtl/hpd_pkg.sv
// Shared constants for the host port outbound DMA read block.
// Assumes nothing beyond a default word width.
package hpd_pkg;
    parameter int HPD_DATA_W = 32;
endpackage

// File: rtl/hpd_hold_stage.sv
// Holding register stage: the internal DMA engine writes it, and the output
// stage takes from it. Assumes `take` is only raised while the stage is full.
// A write in the same cycle as a take refills the register.
module hpd_hold_stage #(
    parameter int DATA_W = hpd_pkg::HPD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              empty,
    output logic [DATA_W-1:0] data
);
    // Empty flag: set on reset or on a take, cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    empty <= 1'b1;
        else if (wr)   empty <= 1'b0;
        else if (take) empty <= 1'b1;
    end

    // Data capture from the internal engine.
    always_ff @(posedge clk) begin
        if (!rst_n)  data <= '0;
        else if (wr) data <= wdata;
    end

    p_take_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wr |=> empty);
    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty);
endmodule

// File: rtl/hpd_out_stage.sv
// Output register stage that the external master reads by acknowledge.
// Assumes `load` is only raised while the stage is empty. An acknowledge
// while the stage is empty changes nothing.
module hpd_out_stage #(
    parameter int DATA_W = hpd_pkg::HPD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ldata,
    input  logic              ack,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Full flag: set by a load, cleared by an acknowledged read.
    always_ff @(posedge clk) begin
        if (!rst_n)          full <= 1'b0;
        else if (load)       full <= 1'b1;
        else if (ack && full) full <= 1'b0;
    end

    // Word capture from the holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= ldata;
    end

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack && full |=> !full);
    p_empty_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full && !load |=> !full && $stable(data));
    p_load_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
endmodule

// File: rtl/hostport_dma_rd.sv
// Top of the host port outbound DMA read handshake. It joins the holding and
// output stages, moves a word across whenever the output is empty and the
// holding register is full, gates the external request with the mode bit,
// and drives the bus only during an acknowledge.
module hostport_dma_rd #(
    parameter int DATA_W = hpd_pkg::HPD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_req_en,
    output logic              ext_req,
    input  logic              ext_ack,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    output logic              hold_empty,
    output logic              out_full
);
    logic              move;
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] out_data;

    // Transfer decision between the two stages.
    always_comb move = !hold_empty && !out_full;

    hpd_hold_stage #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (hold_wr),
        .wdata (hold_wdata),
        .take  (move),
        .empty (hold_empty),
        .data  (hold_data)
    );

    hpd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (move),
        .ldata (hold_data),
        .ack   (ext_ack),
        .full  (out_full),
        .data  (out_data)
    );

    // External request and zero-wait bus drive.
    always_comb begin
        ext_req = out_full && rx_req_en;
        dout_oe = ext_ack;
        dout    = ext_ack ? out_data : '0;
    end

    p_req_drops_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_ack |=> !ext_req);
endmodule

// File: tb/hostport_dma_rd_bench.sv
module hostport_dma_rd_bench;
    localparam int W = 32;
    localparam int NWORDS = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_req_en = 1'b1;
    logic         ext_ack = 1'b0;
    logic         hold_wr = 1'b0;
    logic [W-1:0] hold_wdata = '0;
    logic         ext_req, dout_oe, hold_empty, out_full;
    logic [W-1:0] dout;

    int checks = 0;
    int failures = 0;

    // reference state
    bit          m_hold_full, m_out_full;
    logic [W-1:0] m_hold_data, m_out_data;
    int sent = 0;
    int recvd = 0;

    always #5 clk = ~clk;

    hostport_dma_rd #(.DATA_W(W)) u_hostport_dma_rd (
        .clk(clk), .rst_n(rst_n), .rx_req_en(rx_req_en), .ext_req(ext_req),
        .ext_ack(ext_ack), .dout(dout), .dout_oe(dout_oe), .hold_wr(hold_wr),
        .hold_wdata(hold_wdata), .hold_empty(hold_empty), .out_full(out_full)
    );

    function automatic logic [W-1:0] word_of(int i);
        return 32'hA5000000 ^ (i * 32'h01010101 + 32'h11);
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare all outputs against the model (inputs already applied)
    task automatic compare_all();
        chk("R1/R5 hold_empty", {31'b0, hold_empty}, {31'b0, !m_hold_full});
        chk("R3/R4 out_full", {31'b0, out_full}, {31'b0, m_out_full});
        chk("R2 ext_req", {31'b0, ext_req}, {31'b0, m_out_full && rx_req_en});
        chk("R6 dout_oe", {31'b0, dout_oe}, {31'b0, ext_ack});
        if (ext_ack && m_out_full) chk("R6 dout", dout, m_out_data);
    endtask

    // advance model over one clock edge
    task automatic model_edge();
        bit mv;
        mv = m_hold_full && !m_out_full;
        if (ext_ack && m_out_full) begin
            // R8: delivered word must be the next in sequence
            chk("R8 order", m_out_data, word_of(recvd));
            recvd++;
        end
        if (mv) begin m_out_full = 1; m_out_data = m_hold_data; end
        else if (ext_ack && m_out_full) m_out_full = 0;
        if (hold_wr) begin m_hold_full = 1; m_hold_data = hold_wdata; end
        else if (mv) m_hold_full = 0;
    endtask

    // one cycle: apply inputs at negedge, compare, step model at posedge
    task automatic cycle(bit ack, bit allow_wr);
        ext_ack = ack;
        hold_wr = 0;
        if (allow_wr && hold_empty && sent < NWORDS) begin
            hold_wr = 1; hold_wdata = word_of(sent); sent++;
        end
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_hold_full = 0; m_out_full = 0; m_hold_data = '0; m_out_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 hold_empty", {31'b0, hold_empty}, 32'd1);
        chk("R1 out_full", {31'b0, out_full}, 32'd0);
        chk("R1 ext_req", {31'b0, ext_req}, 32'd0);
        rst_n = 1;
        // R7: acks while empty are ignored
        for (int i = 0; i < 3; i++) cycle(1, 0);
        // R5/R4: one write, then watch it move across
        cycle(0, 1);
        cycle(0, 0);
        cycle(0, 0);
        chk("R4 moved", {31'b0, out_full}, 32'd1);
        // R2: mask the request while data waits
        rx_req_en = 0;
        for (int i = 0; i < 3; i++) cycle(0, 1);
        chk("R2 masked", {31'b0, ext_req}, 32'd0);
        rx_req_en = 1;
        // back-to-back acks with eager engine
        for (int i = 0; i < 40; i++) cycle(1, 1);
        // sparse acks with slow engine
        for (int i = 0; i < 80; i++) cycle((i % 3) == 0, (i % 4) == 1);
        // acknowledge only when requested
        for (int i = 0; i < 200 && recvd < NWORDS; i++) cycle(ext_req, 1);
        // drain anything left
        for (int i = 0; i < 20; i++) cycle(1, 1);
        chk("R8 count", recvd, NWORDS);
        chk("R7 idle out_full", {31'b0, out_full}, 32'd0);
        chk("R1 idle hold_empty", {31'b0, hold_empty}, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule